// File: doc/BRIEF.md
# Bidirectional GPIO Port with Open-Drain Upper Pins

This block is an 8-bit general-purpose I/O port that a processor reaches over a byte-wide register bus. The bus has a single cycle and no wait states. Software sets the level of each pin through an output latch. It sets each pin as input or output through a direction register. The sampled pin levels are read back through the same data address.

The two most significant pins have two extra options in a control register. Each can be switched on its own to open-drain drive. Each can also have its pull-up turned on, whatever its direction. The block does not model analog behaviour. It gives, for every pin, an output value, an output enable and a pull-up enable to an external pad cell, and it takes the raw pin level back in.

Writes take effect on the rising clock edge at which the write enable is high. Read data is a combinational function of the address. Pin inputs pass through a two-stage synchronizer before software can see them.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, the direction register and the control register all hold 0x00. Every pin is then an input (`pad_oe` = 0x00) and no pull-up is on (`pad_pu` = 0x00).
- R2: A write to address 0x03 always updates the output latch, whatever the direction bits hold. For each pin whose direction bit is 1, a read of 0x03 returns that pin's latch bit.
- R3: For each pin whose direction bit is 0, a read of 0x03 returns the pin level seen two rising edges earlier. A write to the latch does not change that value.
- R4: The direction register sits at address 0x07 and can be read and written. A 1 in a bit makes that pin an output.
- R5: A pin whose direction bit is 0 has `pad_oe` low. A push-pull pin whose direction bit is 1 has `pad_oe` high, and `pad_out` equals its latch bit.
- R6: The control register sits at address 0x0A. Bit 3 selects open-drain for pin 7, bit 2 selects open-drain for pin 6, bit 1 turns on the pull-up of pin 7, and bit 0 turns on the pull-up of pin 6. Bits 7:4 always read 0, even after they are written with 1.
- R7: For an open-drain pin whose direction bit is 1, `pad_oe` is high only while the latch bit is 0, and `pad_out` is then 0. Setting an open-drain bit leaves the direction register unchanged.
- R8: `pad_pu[7]` and `pad_pu[6]` follow their pull-up bits whatever the direction bits hold. `pad_pu[5:0]` are always 0.
- R9: A read of any address other than 0x03, 0x07 or 0x0A returns 0x00.
- R10: A write takes effect at the rising edge where `bus_we` is high and is visible in the next cycle. A write to an unmapped address changes no register, and nothing changes while `bus_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable, high to drive |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
Every register bit drives the pad outputs directly, or is one bus read away. A corrupted latch, direction or control bit therefore shows on `pad_out`, `pad_oe` or `pad_pu` in the cycle after the bad write. It can also be read back in the same cycle a read is issued.

A fault in the synchronizer or in the per-bit read mux only shows when direction bits differ across the byte. The stimulus therefore mixes input and output pins and changes the pin levels after the latch has been written. Open-drain faults show only with the direction bit set and the latch at 1, where the enable must drop.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // Register addresses on the byte bus
   localparam int unsigned ADDR_W     = 8;
   localparam int unsigned DATA_ADDR  = 8'h03;
   localparam int unsigned DIR_ADDR   = 8'h07;
   localparam int unsigned CTRL_ADDR  = 8'h0A;

   // Number of implemented control bits (low nibble)
   localparam int unsigned CTRL_BITS  = 4;

   // Control register layout, MSB first: bit3..bit0
   typedef struct packed {
      logic od_hi;   // open-drain, top pin
      logic od_lo;   // open-drain, second pin from top
      logic pu_hi;   // pull-up, top pin
      logic pu_lo;   // pull-up, second pin from top
   } ctrl_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PORT_W-1:0] bus_wdata,
   input  logic [PORT_W-1:0] pin_sync,
   output logic [PORT_W-1:0] bus_rdata,
   output logic [PORT_W-1:0] dat_q,
   output logic [PORT_W-1:0] dir_q,
   output ctrl_t             ctl_q
);
   localparam int unsigned PAD_W = PORT_W - CTRL_BITS;

   generate
      if (PORT_W <= CTRL_BITS) begin : g_bad_width
         $error("gpio_regs: PORT_W must exceed the control field width");
      end
   endgenerate

   logic sel_dat, sel_dir, sel_ctl;
   assign sel_dat = (bus_addr == ADDR_W'(DATA_ADDR));
   assign sel_dir = (bus_addr == ADDR_W'(DIR_ADDR));
   assign sel_ctl = (bus_addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
         dir_q <= '0;
         ctl_q <= '0;
      end else if (bus_we) begin
         if (sel_dat) dat_q <= bus_wdata;
         if (sel_dir) dir_q <= bus_wdata;
         if (sel_ctl) ctl_q <= bus_wdata[CTRL_BITS-1:0];
      end
   end

   // Per-bit data read: output pins return latch, input pins the synced level
   logic [PORT_W-1:0] dat_view;
   genvar b;
   generate
      for (b = 0; b < PORT_W; b++) begin : g_view
         assign dat_view[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_dat)      bus_rdata = dat_view;
      else if (sel_dir) bus_rdata = dir_q;
      else if (sel_ctl) bus_rdata = {{PAD_W{1'b0}}, ctl_q};
   end

   // R2
   dat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_dat) |=> (dat_q == $past(bus_wdata)));

   // R4
   dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_dir) |=> (dir_q == $past(bus_wdata)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(dat_q) && $stable(dir_q) && $stable(ctl_q)));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] dat_q,
   input  logic [PORT_W-1:0] dir_q,
   input  ctrl_t             ctl_q,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_pu
);
   localparam int unsigned HI_PIN = PORT_W - 1;
   localparam int unsigned LO_PIN = PORT_W - 2;

   generate
      if (PORT_W < 2) begin : g_bad_width
         $error("gpio_drive: need at least two pins");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < PORT_W; i++) begin : g_pin
         logic od_en, pu_en;
         if (i == HI_PIN) begin : g_hi
            assign od_en = ctl_q.od_hi;
            assign pu_en = ctl_q.pu_hi;
         end else if (i == LO_PIN) begin : g_lo
            assign od_en = ctl_q.od_lo;
            assign pu_en = ctl_q.pu_lo;
         end else begin : g_plain
            assign od_en = 1'b0;
            assign pu_en = 1'b0;
         end

         // Open-drain: drive only a low, release for a high
         assign pad_oe[i]  = dir_q[i] & ~(od_en & dat_q[i]);
         assign pad_out[i] = dat_q[i] & ~od_en;
         assign pad_pu[i]  = pu_en;

         // R5
         in_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dir_q[i] |-> !pad_oe[i]);

         // R7
         od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (od_en && pad_oe[i]) |-> !pad_out[i]);
      end
   endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_pu
);
   logic [PORT_W-1:0] pin_sync;
   logic [PORT_W-1:0] dat_q, dir_q;
   ctrl_t             ctl_q;

   gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_sync)
   );

   gpio_regs #(.PORT_W(PORT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .pin_sync  (pin_sync),
      .bus_rdata (bus_rdata),
      .dat_q     (dat_q),
      .dir_q     (dir_q),
      .ctl_q     (ctl_q)
   );

   gpio_drive #(.PORT_W(PORT_W)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .dat_q   (dat_q),
      .dir_q   (dir_q),
      .ctl_q   (ctl_q),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pad_pu  (pad_pu)
   );

   // R6
   ctl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata[PORT_W-1:CTRL_BITS] == '0));

   // R9
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != ADDR_W'(DATA_ADDR) && bus_addr != ADDR_W'(DIR_ADDR) &&
       bus_addr != ADDR_W'(CTRL_ADDR)) |-> (bus_rdata == '0));

   // R8
   pu_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pu[PORT_W-3:0] == '0);
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
   localparam int unsigned A_DAT = 8'h03;
   localparam int unsigned A_DIR = 8'h07;
   localparam int unsigned A_CTL = 8'h0A;

   typedef enum logic [1:0] {K_RD, K_OE, K_OUT, K_PU} kind_t;
   typedef struct {
      kind_t      kind;
      logic [7:0] exp;
      string      req;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pad_out, pad_oe, pad_pu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   sb_item_t sb_q[$];

   always #10 clk = ~clk;

   gpio_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pad_pu    (pad_pu)
   );

   // Monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      sb_item_t it;
      logic [7:0] act;
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         case (it.kind)
            K_RD:    act = bus_rdata;
            K_OE:    act = pad_oe;
            K_OUT:   act = pad_out;
            default: act = pad_pu;
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind=%s actual=%02h expected=%02h",
                     it.req, it.kind.name(), act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string r);
      sb_item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.kind = K_RD; it.exp = e; it.req = r;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic exp_pad(input kind_t k, input logic [7:0] e, input string r);
      sb_item_t it;
      @(posedge clk); #1;
      it.kind = k; it.exp = e; it.req = r;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(posedge clk); #1;
      pin_in = v;
      repeat (2) @(posedge clk);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      pin_in = 8'hA5;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      exp_rd(A_DIR[7:0], 8'h00, "R1");
      exp_rd(A_CTL[7:0], 8'h00, "R1");
      exp_pad(K_OE, 8'h00, "R1");
      exp_pad(K_PU, 8'h00, "R1");
      // R3 all inputs: synced pin level
      exp_rd(A_DAT[7:0], 8'hA5, "R3");

      // R3 latch write while input leaves read value
      wr(A_DAT[7:0], 8'h3C);
      exp_rd(A_DAT[7:0], 8'hA5, "R3");
      exp_pad(K_OE, 8'h00, "R5");

      // R4 direction register, R2 mixed read, R5 push-pull drive
      wr(A_DIR[7:0], 8'hF0);
      exp_rd(A_DIR[7:0], 8'hF0, "R4");
      exp_rd(A_DAT[7:0], 8'h35, "R2");
      exp_pad(K_OE, 8'hF0, "R5");
      exp_pad(K_OUT, 8'h3C, "R5");

      // R3 input nibble follows pins after sync
      set_pins(8'h5A);
      exp_rd(A_DAT[7:0], 8'h3A, "R3");

      // R6 control register, upper bits read 0
      wr(A_CTL[7:0], 8'hFF);
      exp_rd(A_CTL[7:0], 8'h0F, "R6");
      exp_rd(A_DIR[7:0], 8'hF0, "R7");
      // R7 open-drain with latch low: drives low
      exp_pad(K_OE, 8'hF0, "R7");
      exp_pad(K_OUT, 8'h3C, "R7");
      // R7 open-drain with latch high: released
      wr(A_DAT[7:0], 8'hFC);
      exp_pad(K_OE, 8'h30, "R7");
      exp_pad(K_OUT, 8'h3C, "R7");
      exp_rd(A_DAT[7:0], 8'hFA, "R2");

      // R8 pull-ups independent of direction
      exp_pad(K_PU, 8'hC0, "R8");
      wr(A_DIR[7:0], 8'h00);
      exp_pad(K_PU, 8'hC0, "R8");
      exp_pad(K_OE, 8'h00, "R5");
      wr(A_CTL[7:0], 8'h02);
      exp_pad(K_PU, 8'h80, "R8");
      wr(A_CTL[7:0], 8'h01);
      exp_pad(K_PU, 8'h40, "R8");

      // R7 per-pin open-drain select (pin 6 only), R6 bit positions
      wr(A_CTL[7:0], 8'h04);
      wr(A_DIR[7:0], 8'hC0);
      wr(A_DAT[7:0], 8'h40);
      exp_pad(K_OE, 8'h80, "R7");
      exp_pad(K_OUT, 8'h00, "R7");
      wr(A_DAT[7:0], 8'h80);
      exp_pad(K_OE, 8'hC0, "R6");
      exp_pad(K_OUT, 8'h80, "R6");
      exp_pad(K_PU, 8'h00, "R8");

      // R9 unmapped reads
      exp_rd(8'h00, 8'h00, "R9");
      exp_rd(8'h05, 8'h00, "R9");
      exp_rd(8'hFF, 8'h00, "R9");

      // R10 write to unmapped address changes nothing
      wr(8'h05, 8'hFF);
      exp_rd(A_DIR[7:0], 8'hC0, "R10");
      exp_rd(A_CTL[7:0], 8'h04, "R10");
      exp_pad(K_OUT, 8'h80, "R10");

      // R10 data on bus without strobe changes nothing
      @(posedge clk); #1;
      bus_addr = A_DIR[7:0]; bus_wdata = 8'h0F;
      repeat (2) @(posedge clk);
      exp_rd(A_DIR[7:0], 8'hC0, "R10");

      // R1 reset again clears everything
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      exp_pad(K_OE, 8'h00, "R1");
      exp_pad(K_PU, 8'h00, "R1");
      exp_rd(A_CTL[7:0], 8'h00, "R1");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule